// File: doc/BRIEF.md
# Clock and Power-Mode Controller

This block sits between the PLL output and the rest of a small microcontroller. It produces a gated processor clock, a peripheral clock and one gated clock per peripheral. It also drives the oscillator enable. Software chooses the sleep depth, the peripheral clock ratio and which peripherals get a clock through four small configuration registers.

There are two sleep depths. Light sleep stops only the processor clock. The peripheral clock divider keeps running from the ungated PLL output, so peripherals can still raise an interrupt, and any such interrupt brings the processor back. Deep sleep stops every output clock and drops the oscillator enable. Only a masked set of wake lines ends deep sleep. These lines act asynchronously on their level, with no clock needed. The processor is released only after a settle interval counted in oscillator cycles. Every output clock passes through a glitch-free gate whose enable is captured while the source clock is low.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset the controller is in run state. `osc_en` is 1, `cpu_clk` pulses on every `clk_src` cycle, and `pclk` and every `periph_clk` bit pulse once every 4 `clk_src` cycles.
- R2: Registers are written on a rising `clk_src` edge when `cfg_we` is 1, and read combinationally on `cfg_rdata`, zero-extended. The address map is: 0 = mode (bits 1:0), 1 = ratio code (bits 1:0), 2 = peripheral enables (bits NPERIPH-1:0), 3 = wake mask (bits NWAKE-1:0). The reset values are mode 0, ratio 0, enables all ones and mask 0.
- R3: Writing mode bit 0 alone (value 1) enters light sleep. `cpu_clk` stops, while `pclk` and the enabled peripheral clocks keep their rate.
- R4: In light sleep, `irq_any` high at a rising edge returns the controller to run. `cpu_clk` then resumes and the mode register reads 0.
- R5: Writing mode bit 1 enters deep sleep, even when bit 0 is also set. `osc_en` goes to 0, all output clocks stop, and `irq_any` has no effect.
- R6: In deep sleep, a high `wake_lines` bit whose mask bit is 1 raises `osc_en` at once, with no clock edge needed. Wake lines whose mask bit is 0 are ignored.
- R7: After a deep-sleep wake, `cpu_clk` and `pclk` stay silent for at least SETTLE_CYC `clk_osc` cycles. `cpu_clk` resumes within SETTLE_CYC+10 cycles, and the mode register then reads 0.
- R8: The ratio code sets the `pclk` rate relative to `clk_src`: 01 gives divide by 1, 10 gives divide by 2, and 00 and 11 give divide by 4.
- R9: A new ratio code takes effect only at the end of a full divider period. Rapid ratio writes never produce a shortened `pclk` pulse.
- R10: Bit i of the peripheral enable register gates `periph_clk[i]`. An enabled bit pulses at the `pclk` rate, and a disabled bit stays low.
- R11: Every pulse on `cpu_clk`, `pclk` and `periph_clk` lasts one full high phase of `clk_src`, across all mode, ratio and enable changes.
- R12: Reset during light sleep returns the controller to run with a running `cpu_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | PLL output, source of all generated clocks |
| clk_osc | input | 1 | Oscillator clock, paces the settle interval |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data |
| irq_any | input | 1 | Combined enabled interrupt, ends light sleep |
| wake_lines | input | NWAKE | Clock-free wake sources for deep sleep |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk | output | 1 | Gated processor clock |
| pclk | output | 1 | Divided peripheral clock |
| periph_clk | output | NPERIPH | Per-peripheral gated clocks |

## Verification
A ratio boundary in the divider can fall in the same `clk_src` cycle as a sleep-state change that alters the gate enables. In that cycle both the divider tick and the run or sleep decision feed the `pclk` gate. The bench provokes this by switching ratios back to back and by entering and leaving both sleep depths at arbitrary divider phases. It then judges each collision by measuring the high time of every output pulse and by counting pulses over fixed windows, which must match the ratio and the mode.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_DOWN   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_t;

  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_RATIO = 2'd1;
  localparam logic [1:0] A_PEN   = 2'd2;
  localparam logic [1:0] A_WMASK = 2'd3;

  // ratio code to division factor; reserved code falls back to 4
  function automatic logic [2:0] div_ratio(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // requested state from the mode bits; deep sleep wins
  function automatic pm_state_t mode_target(input logic [1:0] m);
    if (m[1])      return PM_DOWN;
    else if (m[0]) return PM_IDLE;
    else           return PM_RUN;
  endfunction

endpackage

// File: rtl/clkpm_gate.sv
module clkpm_gate (
  input  logic clk_in,
  input  logic en,
  output logic clk_out
);
  logic en_l;

  // enable captured only while the clock is low
  always_latch begin
    if (!clk_in) en_l = en;
  end

  assign clk_out = clk_in & en_l;
endmodule

// File: rtl/clkpm_regs.sv
module clkpm_regs
  import clkpm_pkg::*;
#(
  parameter int NPERIPH = 4,
  parameter int NWAKE   = 4,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic               mode_clr,
  output logic [1:0]         mode_q,
  output logic [1:0]         ratio_q,
  output logic [NPERIPH-1:0] pen_q,
  output logic [NWAKE-1:0]   mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ratio_q <= '0;
      pen_q   <= '1;
      mask_q  <= '0;
    end else begin
      if (we) begin
        case (addr)
          A_MODE:  mode_q  <= wdata[1:0];
          A_RATIO: ratio_q <= wdata[1:0];
          A_PEN:   pen_q   <= wdata[NPERIPH-1:0];
          A_WMASK: mask_q  <= wdata[NWAKE-1:0];
          default: ;
        endcase
      end
      // hardware clear on wake outranks a software write
      if (mode_clr) mode_q <= '0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE:  rdata[1:0]         = mode_q;
      A_RATIO: rdata[1:0]         = ratio_q;
      A_PEN:   rdata[NPERIPH-1:0] = pen_q;
      A_WMASK: rdata[NWAKE-1:0]   = mask_q;
      default: rdata = '0;
    endcase
  end

  p_mode_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> (mode_q == 2'b00));

  p_ratio_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_RATIO) |=> (ratio_q == $past(wdata[1:0])));

endmodule

// File: rtl/clkpm_div.sv
module clkpm_div
  import clkpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       tick
);
  logic [1:0] cnt_q;
  logic [2:0] n_q;
  logic       last;

  assign last = ({1'b0, cnt_q} == (n_q - 3'd1));
  assign tick = (cnt_q == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= 3'd4;
    end else if (last) begin
      cnt_q <= '0;
      n_q   <= div_ratio(code);   // new ratio only at a period end
    end else begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(n_q));

  p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && n_q != 3'd1) |=> !tick);

endmodule

// File: rtl/clkpm_fsm.sv
module clkpm_fsm
  import clkpm_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int NWAKE      = 4
) (
  input  logic             clk_src,
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic [1:0]       mode_q,
  input  logic             irq_any,
  input  logic [NWAKE-1:0] wake_lines,
  input  logic [NWAKE-1:0] wake_mask,
  output pm_state_t        state_o,
  output logic             mode_clr,
  output logic             osc_en
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SLIM = SW'(SETTLE_CYC);

  pm_state_t     state_q, state_d;
  logic          wake_hit, enter_pd, pd_hold;
  logic          settle_req, req_s1, req_s2, settle_done_osc;
  logic          done_s1, done_s2;
  logic [SW-1:0] scnt_q;

  assign wake_hit = |(wake_lines & wake_mask);
  assign enter_pd = (state_q == PM_RUN) && mode_q[1];

  // deep-sleep hold, cleared by the wake level without a clock
  always_ff @(posedge clk_src or negedge rst_n or posedge wake_hit) begin
    if (!rst_n)        pd_hold <= 1'b0;
    else if (wake_hit) pd_hold <= 1'b0;
    else if (enter_pd) pd_hold <= 1'b1;
  end

  assign osc_en = !pd_hold;

  always_comb begin
    state_d  = state_q;
    mode_clr = 1'b0;
    case (state_q)
      PM_RUN:    state_d = mode_target(mode_q);
      PM_IDLE:   if (irq_any) begin state_d = PM_RUN; mode_clr = 1'b1; end
      PM_DOWN:   if (!pd_hold) state_d = PM_SETTLE;
      PM_SETTLE: if (done_s2) begin state_d = PM_RUN; mode_clr = 1'b1; end
      default:   state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign settle_req = (state_q == PM_SETTLE);

  // settle counter in the oscillator domain
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      scnt_q <= '0;
    end else begin
      req_s1 <= settle_req;
      req_s2 <= req_s1;
      if (!req_s2)           scnt_q <= '0;
      else if (scnt_q != SLIM) scnt_q <= scnt_q + 1'b1;
    end
  end

  assign settle_done_osc = (scnt_q == SLIM);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      done_s1 <= 1'b0;
      done_s2 <= 1'b0;
    end else begin
      done_s1 <= settle_done_osc;
      done_s2 <= done_s1;
    end
  end

  assign state_o = state_q;

  p_idle_exit_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
    (state_q == PM_IDLE && irq_any) |=> (state_q == PM_RUN));

  p_pd_priority_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
    (state_q == PM_RUN && mode_q == 2'b11) |=> (state_q == PM_DOWN));

  p_down_exit_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
    (state_q == PM_DOWN) |=> (state_q == PM_DOWN || state_q == PM_SETTLE));

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int NPERIPH    = 4,
  parameter int NWAKE      = 4,
  parameter int SETTLE_CYC = 16,
  parameter int DW         = 8
) (
  input  logic               clk_src,
  input  logic               clk_osc,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  input  logic               irq_any,
  input  logic [NWAKE-1:0]   wake_lines,
  output logic               osc_en,
  output logic               cpu_clk,
  output logic               pclk,
  output logic [NPERIPH-1:0] periph_clk
);
  logic [1:0]         mode_q, ratio_q;
  logic [NPERIPH-1:0] pen_q;
  logic [NWAKE-1:0]   mask_q;
  logic               mode_clr, tick;
  pm_state_t          state;

  // named gate enables for the checks
  logic               cpu_gate_en, periph_run, pclk_gate_en;
  logic [NPERIPH-1:0] per_gate_en;

  clkpm_regs #(.NPERIPH(NPERIPH), .NWAKE(NWAKE), .DW(DW)) u_regs (
    .clk(clk_src), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .mode_clr(mode_clr),
    .mode_q(mode_q), .ratio_q(ratio_q), .pen_q(pen_q), .mask_q(mask_q)
  );

  clkpm_div u_div (
    .clk(clk_src), .rst_n(rst_n), .code(ratio_q), .tick(tick)
  );

  clkpm_fsm #(.SETTLE_CYC(SETTLE_CYC), .NWAKE(NWAKE)) u_fsm (
    .clk_src(clk_src), .clk_osc(clk_osc), .rst_n(rst_n),
    .mode_q(mode_q), .irq_any(irq_any), .wake_lines(wake_lines),
    .wake_mask(mask_q), .state_o(state), .mode_clr(mode_clr),
    .osc_en(osc_en)
  );

  assign cpu_gate_en  = (state == PM_RUN);
  assign periph_run   = (state == PM_RUN) || (state == PM_IDLE);
  assign pclk_gate_en = periph_run && tick;

  clkpm_gate u_gate_cpu (.clk_in(clk_src), .en(cpu_gate_en),  .clk_out(cpu_clk));
  clkpm_gate u_gate_pcl (.clk_in(clk_src), .en(pclk_gate_en), .clk_out(pclk));

  for (genvar i = 0; i < NPERIPH; i++) begin : g_per
    assign per_gate_en[i] = pclk_gate_en && pen_q[i];
    clkpm_gate u_gate (.clk_in(clk_src), .en(per_gate_en[i]), .clk_out(periph_clk[i]));
  end

  p_osc_off_quiet_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
    !osc_en |-> (!cpu_gate_en && !pclk_gate_en && per_gate_en == '0));

endmodule

// File: tb/sim_clkpm_ctrl.sv
`timescale 1ns/1ps
module sim_clkpm_ctrl;
  localparam int NP = 4;
  localparam int NW = 4;
  localparam int SC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          irq_any = 1'b0;
  logic [NW-1:0] wake_lines = '0;
  logic          osc_en, cpu_clk, pclk;
  logic [NP-1:0] periph_clk;

  always #4 clk = ~clk;   // 125 MHz

  clkpm_ctrl #(.NPERIPH(NP), .NWAKE(NW), .SETTLE_CYC(SC), .DW(8)) u0 (
    .clk_src(clk), .clk_osc(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_any(irq_any), .wake_lines(wake_lines), .osc_en(osc_en),
    .cpu_clk(cpu_clk), .pclk(pclk), .periph_clk(periph_clk)
  );

  int checks = 0, fails = 0, shorts = 0;
  int cpu_cnt = 0, pclk_cnt = 0;
  int per_cnt [NP];
  bit finished = 0;

  always @(posedge cpu_clk) cpu_cnt = cpu_cnt + 1;
  always @(posedge pclk)    pclk_cnt = pclk_cnt + 1;
  for (genvar g = 0; g < NP; g++) begin : g_pc
    always @(posedge periph_clk[g]) per_cnt[g] = per_cnt[g] + 1;
  end

  // pulse-width monitor: a full high phase is 4 ns
  realtime t_cpu = 0, t_pcl = 0, t_p0 = 0;
  always @(posedge cpu_clk)       t_cpu = $realtime;
  always @(posedge pclk)          t_pcl = $realtime;
  always @(posedge periph_clk[0]) t_p0  = $realtime;
  always @(negedge cpu_clk)       if (t_cpu > 0 && $realtime - t_cpu < 3.9) shorts = shorts + 1;
  always @(negedge pclk)          if (t_pcl > 0 && $realtime - t_pcl < 3.9) shorts = shorts + 1;
  always @(negedge periph_clk[0]) if (t_p0 > 0 && $realtime - t_p0 < 3.9) shorts = shorts + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = int'(cfg_rdata);
  endtask

  task automatic win(input int n);
    @(negedge clk);
    cpu_cnt = 0; pclk_cnt = 0;
    for (int k = 0; k < NP; k++) per_cnt[k] = 0;
    repeat (n) @(negedge clk);
  endtask

  // {ratio code, expected pclk pulses in 40 cycles}
  localparam logic [7:0] DIV_VEC [4] = '{
    {2'b01, 6'd40}, {2'b10, 6'd20}, {2'b11, 6'd10}, {2'b00, 6'd10}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2 reset state
    chk("R1 osc_en", int'(osc_en), 1);
    rd(2'd0, v); chk("R2 mode reset", v, 0);
    rd(2'd1, v); chk("R2 ratio reset", v, 0);
    rd(2'd2, v); chk("R2 enable reset", v, 15);
    rd(2'd3, v); chk("R2 mask reset", v, 0);
    win(40);
    chk("R1 cpu rate", cpu_cnt, 40);
    chk("R1 pclk rate", pclk_cnt, 10);
    chk("R1 periph3 rate", per_cnt[3], 10);

    // R8 ratio table
    for (int i = 0; i < 4; i++) begin
      wr(2'd1, {6'd0, DIV_VEC[i][7:6]});
      rd(2'd1, v); chk("R2 ratio readback", v, int'(DIV_VEC[i][7:6]));
      repeat (6) @(negedge clk);
      win(40);
      chk("R8 pclk rate", pclk_cnt, int'(DIV_VEC[i][5:0]));
      chk("R10 periph0 follows pclk", per_cnt[0], int'(DIV_VEC[i][5:0]));
    end

    // R9 back-to-back ratio writes
    for (int j = 0; j < 5; j++) begin
      wr(2'd1, 8'd1); wr(2'd1, 8'd2);
      repeat (j) @(negedge clk);
      wr(2'd1, 8'd0);
    end
    repeat (8) @(negedge clk);
    chk("R9 no short pulses", shorts, 0);
    win(40);
    chk("R9 final ratio", pclk_cnt, 10);

    // R10 per-peripheral enables
    wr(2'd2, 8'b0101);
    repeat (4) @(negedge clk);
    win(40);
    chk("R10 periph0 on", per_cnt[0], 10);
    chk("R10 periph1 off", per_cnt[1], 0);
    chk("R10 periph2 on", per_cnt[2], 10);
    chk("R10 periph3 off", per_cnt[3], 0);

    // R3 light sleep
    wr(2'd0, 8'd1);
    repeat (4) @(negedge clk);
    win(40);
    chk("R3 cpu stopped", cpu_cnt, 0);
    chk("R3 pclk running", pclk_cnt, 10);
    chk("R3 periph0 running", per_cnt[0], 10);

    // R4 interrupt exit
    @(negedge clk); irq_any = 1'b1;
    @(negedge clk); irq_any = 1'b0;
    repeat (3) @(negedge clk);
    win(40);
    chk("R4 cpu resumed", cpu_cnt, 40);
    rd(2'd0, v); chk("R4 mode cleared", v, 0);

    // R5 deep sleep, both bits set
    wr(2'd3, 8'b0001);
    wr(2'd0, 8'd3);
    repeat (4) @(negedge clk);
    chk("R5 osc off", int'(osc_en), 0);
    win(40);
    chk("R5 cpu quiet", cpu_cnt, 0);
    chk("R5 pclk quiet", pclk_cnt, 0);
    chk("R5 periph0 quiet", per_cnt[0], 0);
    @(negedge clk); irq_any = 1'b1;
    @(negedge clk); irq_any = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 irq ignored", int'(osc_en), 0);

    // R6 masked line ignored, enabled line wakes without a clock
    @(negedge clk); wake_lines = 4'b0100;
    repeat (3) @(negedge clk);
    chk("R6 masked wake ignored", int'(osc_en), 0);
    wake_lines = 4'b0000;
    @(negedge clk);
    cpu_cnt = 0; pclk_cnt = 0;
    #1 wake_lines = 4'b0001;
    #1 chk("R6 async wake", int'(osc_en), 1);
    n = 0;
    while (cpu_cnt == 0 && n < 64) begin
      @(negedge clk);
      n++;
      if (n == SC) chk("R7 pclk silent during settle", pclk_cnt, 0);
      if (n == 2) wake_lines = 4'b0000;
    end
    chk_rng("R7 settle length", n, SC, SC + 10);
    rd(2'd0, v); chk("R7 mode cleared", v, 0);

    // R12 reset while in light sleep
    wr(2'd0, 8'd1);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    win(20);
    chk("R12 cpu after reset", cpu_cnt, 20);
    rd(2'd0, v); chk("R12 mode after reset", v, 0);

    chk("R11 all pulses full width", shorts, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule